// File: doc/BRIEF.md
# Program and Data Space Access Router

This block sits between a small byte-oriented controller core and its memories. Each access the core makes is one of three kinds: an instruction fetch, a data read, or a data write. Each carries a 16-bit address. The block decides whether the access is served by the on-chip flash, the on-chip data SRAM, or the external expansion bus. Instruction and data spaces are separate, so the same address can land in different places depending on the access kind.

A run-time configuration register holds two things. The first is a 3-bit code that places the top of on-chip program space at a power of two, from nothing up to the full 16 KB of flash. The second is an overlay bit that opens a 1 KB window of the data SRAM as program space directly above that top. Data accesses reach the SRAM below 1 KB and go external above it. External accesses drive the matching active-low strobe: fetch strobe, read strobe or write strobe.

Requests arrive on a valid/ready interface. The core holds `req_valid`, `req_kind` and `req_addr` stable until it sees `req_ready` high at a rising edge. That edge accepts the request. Internal accesses occupy one cycle and never withdraw ready. An external access occupies `EXT_CYCLES` cycles, and ready stays low for all but the last of them. Routing is decided once, at acceptance, from the configuration held at that moment.

Top module: `mem_space_decoder`

## Requirements
- R1: A fetch accepted at an address below the on-chip program top asserts `sel_flash` alone, in the cycle after the accepting edge, for one cycle.
- R2: Code c selects a program top of 0 bytes for c=0 and 2^(7+c) bytes for c=1..7, so c=7 is 16 KB. After reset the code is 7 and the overlay bit is 0.
- R3: With the overlay bit set, a fetch at an address from the program top up to the top plus 1023 asserts `sel_sram`.
- R4: A fetch not served on-chip asserts `ext_access` and drives `psen_n` low.
- R5: A data read or write below address 0x0400 asserts `sel_sram`. A data access never asserts `sel_flash`.
- R6: A data read at or above 0x0400 drives `rd_n` low, and a data write there drives `wr_n` low, each together with `ext_access`.
- R7: An external access holds its outputs for `EXT_CYCLES` cycles with `req_ready` low in all but the last. An internal access keeps `req_ready` high.
- R8: At most one of `sel_flash`, `sel_sram` and `ext_access` is high at a time. At most one strobe is low. With no access in progress, all three strobes are high.
- R9: A configuration write reaches only requests accepted at a later edge. A request accepted at the same edge, or already in progress, keeps its routing.
- R10: A request with kind code 2'b11 is ignored: no select and no strobe follows it. Kind codes are 2'b00 fetch, 2'b01 data read, 2'b10 data write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load configuration this cycle |
| cfg_code | input | 3 | Program top code to load |
| cfg_overlay | input | 1 | Overlay bit to load |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | Access kind (fetch, read, write, none) |
| req_addr | input | 16 | Access address |
| req_ready | output | 1 | Request accepted at this edge if valid |
| sel_flash | output | 1 | On-chip flash selected |
| sel_sram | output | 1 | On-chip data SRAM selected |
| ext_access | output | 1 | External bus access in progress |
| psen_n | output | 1 | External fetch strobe, active low |
| rd_n | output | 1 | External read strobe, active low |
| wr_n | output | 1 | External write strobe, active low |

## Verification
The selects and strobes are registered, so they are due one clock after the edge that accepts the request. The bench samples them one time unit after that edge, with inputs driven on the falling edge. An external access must then stay visible for `EXT_CYCLES-1` further edges, with ready returning high in the last cycle, and the bench counts exactly that many edges before it checks ready. The outputs must be idle one edge later. Configuration writes are checked both at the same edge as an acceptance and during a busy external access, before the next request.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  typedef enum logic [1:0] {
    KIND_FETCH = 2'b00,
    KIND_XRD   = 2'b01,
    KIND_XWR   = 2'b10,
    KIND_NONE  = 2'b11
  } kind_e;

  typedef enum logic [1:0] {
    DST_NONE  = 2'b00,
    DST_FLASH = 2'b01,
    DST_SRAM  = 2'b10,
    DST_EXT   = 2'b11
  } dst_e;
endpackage

// File: rtl/mdec_cfg.sv
module mdec_cfg #(
  parameter int CODE_W     = 3,
  parameter int RESET_CODE = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              overlay_i,
  output logic [CODE_W-1:0] code_o,
  output logic              overlay_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_o    <= CODE_W'(RESET_CODE);
      overlay_o <= 1'b0;
    end else if (we_i) begin
      code_o    <= code_i;
      overlay_o <= overlay_i;
    end
  end
endmodule

// File: rtl/mdec_route.sv
module mdec_route
  import mdec_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int FLASH_AW = 14,
  parameter int SRAM_AW  = 10,
  parameter int CODE_W   = 3
) (
  input  kind_e             kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              overlay_i,
  output dst_e              dst_o
);
  localparam int LIM_W      = ADDR_W + 1;
  localparam int MAX_CODE   = (1 << CODE_W) - 1;
  localparam int SHIFT_BASE = FLASH_AW - MAX_CODE;
  localparam logic [LIM_W-1:0] SRAM_BYTES = LIM_W'(1) << SRAM_AW;

  logic [LIM_W-1:0] prog_top;
  logic [LIM_W-1:0] win_top;
  logic [LIM_W-1:0] addr_x;

  assign addr_x = {1'b0, addr_i};

  always_comb begin
    if (code_i == '0) prog_top = '0;
    else              prog_top = LIM_W'(1) << (SHIFT_BASE + int'(code_i));
    win_top = prog_top + SRAM_BYTES;
  end

  always_comb begin
    dst_o = DST_NONE;
    unique case (kind_i)
      KIND_FETCH: begin
        if (addr_x < prog_top)                  dst_o = DST_FLASH;
        else if (overlay_i && addr_x < win_top) dst_o = DST_SRAM;
        else                                    dst_o = DST_EXT;
      end
      KIND_XRD, KIND_XWR: begin
        if (addr_x < SRAM_BYTES) dst_o = DST_SRAM;
        else                     dst_o = DST_EXT;
      end
      default: dst_o = DST_NONE;
    endcase
  end
endmodule

// File: rtl/mdec_access.sv
module mdec_access
  import mdec_pkg::*;
#(
  parameter int EXT_CYCLES = 3
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  valid_i,
  input  kind_e kind_i,
  input  dst_e  dst_i,
  output logic  ready_o,
  output dst_e  dst_o,
  output kind_e kind_o
);
  localparam int CNT_W = (EXT_CYCLES > 1) ? $clog2(EXT_CYCLES) : 1;

  logic             active;
  logic [CNT_W-1:0] remain;
  logic             accept;

  assign ready_o = !active || (remain == '0);
  assign accept  = valid_i && ready_o && (kind_i != KIND_NONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      remain <= '0;
      dst_o  <= DST_NONE;
      kind_o <= KIND_NONE;
    end else if (accept) begin
      active <= 1'b1;
      dst_o  <= dst_i;
      kind_o <= kind_i;
      remain <= (dst_i == DST_EXT) ? CNT_W'(EXT_CYCLES - 1) : '0;
    end else if (active) begin
      if (remain == '0) begin
        active <= 1'b0;
        dst_o  <= DST_NONE;
        kind_o <= KIND_NONE;
      end else begin
        remain <= remain - 1'b1;
      end
    end
  end
endmodule

// File: rtl/mem_space_decoder.sv
module mem_space_decoder
  import mdec_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int FLASH_AW   = 14,
  parameter int SRAM_AW    = 10,
  parameter int CODE_W     = 3,
  parameter int EXT_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CODE_W-1:0] cfg_code,
  input  logic              cfg_overlay,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              sel_flash,
  output logic              sel_sram,
  output logic              ext_access,
  output logic              psen_n,
  output logic              rd_n,
  output logic              wr_n
);
  localparam int RESET_CODE = (1 << CODE_W) - 1;

  logic [CODE_W-1:0] cur_code;
  logic              cur_overlay;
  dst_e              new_dst;
  dst_e              act_dst;
  kind_e             act_kind;
  kind_e             in_kind;

  assign in_kind = kind_e'(req_kind);

  mdec_cfg #(.CODE_W(CODE_W), .RESET_CODE(RESET_CODE)) i_cfg (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .code_i(cfg_code),
    .overlay_i(cfg_overlay), .code_o(cur_code), .overlay_o(cur_overlay)
  );

  mdec_route #(.ADDR_W(ADDR_W), .FLASH_AW(FLASH_AW), .SRAM_AW(SRAM_AW),
               .CODE_W(CODE_W)) i_route (
    .kind_i(in_kind), .addr_i(req_addr), .code_i(cur_code),
    .overlay_i(cur_overlay), .dst_o(new_dst)
  );

  mdec_access #(.EXT_CYCLES(EXT_CYCLES)) i_access (
    .clk(clk), .rst_n(rst_n), .valid_i(req_valid), .kind_i(in_kind),
    .dst_i(new_dst), .ready_o(req_ready), .dst_o(act_dst), .kind_o(act_kind)
  );

  always_comb begin
    sel_flash  = (act_dst == DST_FLASH);
    sel_sram   = (act_dst == DST_SRAM);
    ext_access = (act_dst == DST_EXT);
    psen_n     = !(ext_access && act_kind == KIND_FETCH);
    rd_n       = !(ext_access && act_kind == KIND_XRD);
    wr_n       = !(ext_access && act_kind == KIND_XWR);
  end
endmodule

// File: rtl/mdec_checks.sv
module mdec_checks (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic [1:0] req_kind,
  input logic       req_ready,
  input logic       sel_flash,
  input logic       sel_sram,
  input logic       ext_access,
  input logic       psen_n,
  input logic       rd_n,
  input logic       wr_n
);
  assert_one_target_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sel_flash, sel_sram, ext_access}));

  assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!psen_n, !rd_n, !wr_n}) <= 1);

  assert_idle_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_access |-> (psen_n && rd_n && wr_n));

  assert_data_no_flash_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (req_kind == 2'b01 || req_kind == 2'b10)) |=> !sel_flash);

  assert_internal_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_flash || sel_sram) |-> req_ready);

  assert_hold_route_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_access && !req_ready) |=> (ext_access && $stable({psen_n, rd_n, wr_n})));

  assert_ignore_none_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && (!req_valid || req_kind == 2'b11)) |=> !(sel_flash || sel_sram || ext_access));
endmodule

bind mem_space_decoder mdec_checks i_checks (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .req_ready(req_ready), .sel_flash(sel_flash), .sel_sram(sel_sram),
  .ext_access(ext_access), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n)
);

// File: tb/test_mem_space_decoder.sv
module test_mem_space_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int EXT        = 3;
  localparam int D_NONE = 0, D_FLASH = 1, D_SRAM = 2, D_EXT = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_code = 3'd7;
  logic        cfg_overlay = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = 2'b11;
  logic [15:0] req_addr = '0;
  logic        req_ready, sel_flash, sel_sram, ext_access, psen_n, rd_n, wr_n;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = !clk;

  mem_space_decoder #(.EXT_CYCLES(EXT)) i_mem_space_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_code(cfg_code),
    .cfg_overlay(cfg_overlay), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_ready(req_ready), .sel_flash(sel_flash),
    .sel_sram(sel_sram), .ext_access(ext_access), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int out_dst();
    return sel_flash ? D_FLASH : sel_sram ? D_SRAM : ext_access ? D_EXT : D_NONE;
  endfunction

  function automatic int strobes();
    return {29'd0, psen_n, rd_n, wr_n};
  endfunction

  function automatic int exp_strobes(input int kind, input int dst);
    if (dst != D_EXT) return 7;
    return kind == 0 ? 3 : kind == 1 ? 5 : 6;
  endfunction

  task automatic check_idle(input string req);
    check(req, "idle target", out_dst(), D_NONE);
    check(req, "idle strobes", strobes(), 7);
  endtask

  task automatic set_cfg(input int code, input bit ovl);
    @(negedge clk);
    cfg_we = 1'b1; cfg_code = 3'(code); cfg_overlay = ovl;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic issue(input int kind, input int addr, input int exp, input string req);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'(kind); req_addr = 16'(addr);
    @(posedge clk); #1;
    check(req, $sformatf("target @%h", addr), out_dst(), exp);
    check(req, "strobes", strobes(), exp_strobes(kind, exp));
    check("R7", "ready after accept", int'(req_ready), (exp == D_EXT && EXT > 1) ? 0 : 1);
    @(negedge clk);
    req_valid = 1'b0; req_kind = 2'b11;
    if (exp == D_EXT) begin
      repeat (EXT - 1) @(posedge clk);
      #1;
      check("R7", "ext still held", out_dst(), D_EXT);
      check("R7", "ready in last ext cycle", int'(req_ready), 1);
    end
    @(posedge clk); #1;
    check_idle("R8");
  endtask

  task automatic t_reset();
    check("R8", "ready at reset", int'(req_ready), 1);
    check_idle("R8");
  endtask

  task automatic t_default_top();
    issue(0, 16'h0000, D_FLASH, "R1");
    issue(0, 16'h3FFF, D_FLASH, "R2");
    issue(0, 16'h4000, D_EXT, "R4");
    issue(0, 16'hFFFF, D_EXT, "R4");
  endtask

  task automatic t_codes();
    for (int c = 0; c < 8; c++) begin
      int top;
      top = (c == 0) ? 0 : (1 << (7 + c));
      set_cfg(c, 1'b0);
      if (top > 0) issue(0, top - 1, D_FLASH, "R2");
      issue(0, top, D_EXT, "R2");
    end
  endtask

  task automatic t_overlay();
    set_cfg(5, 1'b1);
    issue(0, 16'h0FFF, D_FLASH, "R3");
    issue(0, 16'h1000, D_SRAM, "R3");
    issue(0, 16'h13FF, D_SRAM, "R3");
    issue(0, 16'h1400, D_EXT, "R3");
    set_cfg(0, 1'b1);
    issue(0, 16'h0000, D_SRAM, "R3");
    issue(0, 16'h0400, D_EXT, "R3");
    set_cfg(7, 1'b0);
  endtask

  task automatic t_data();
    issue(1, 16'h0100, D_SRAM, "R5");
    issue(1, 16'h03FF, D_SRAM, "R5");
    issue(2, 16'h0000, D_SRAM, "R5");
    issue(1, 16'h0400, D_EXT, "R6");
    issue(2, 16'hFFFF, D_EXT, "R6");
    issue(2, 16'h2000, D_EXT, "R6");
  endtask

  task automatic t_cfg_timing();
    set_cfg(5, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b00; req_addr = 16'h2000;
    @(posedge clk); #1;
    check("R9", "ext before write", out_dst(), D_EXT);
    @(negedge clk);
    req_valid = 1'b0; req_kind = 2'b11;
    cfg_we = 1'b1; cfg_code = 3'd7;
    @(posedge clk); #1;
    check("R9", "in-progress keeps route", out_dst(), D_EXT);
    check("R9", "in-progress strobes", strobes(), 3);
    @(negedge clk);
    cfg_we = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check_idle("R9");
    issue(0, 16'h2000, D_FLASH, "R9");
    @(negedge clk);
    cfg_we = 1'b1; cfg_code = 3'd0;
    req_valid = 1'b1; req_kind = 2'b00; req_addr = 16'h0010;
    @(posedge clk); #1;
    check("R9", "same-edge write uses old top", out_dst(), D_FLASH);
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0; req_kind = 2'b11;
    @(posedge clk); #1;
    check_idle("R9");
    issue(0, 16'h0010, D_EXT, "R9");
    set_cfg(7, 1'b0);
  endtask

  task automatic t_none();
    @(negedge clk);
    req_valid = 1'b1; req_kind = 2'b11; req_addr = 16'h5000;
    @(posedge clk); #1;
    check_idle("R10");
    @(posedge clk); #1;
    check_idle("R10");
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_top();
    t_codes();
    t_overlay();
    t_data();
    t_cfg_timing();
    t_none();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule